// File: doc/BRIEF.md
# Serial DAC Word Loader

This block sits between a host and a serially loaded multiplying DAC. It converts one parallel request into the converter's bit-serial load sequence. The host offers a 16-bit container on a valid/ready handshake. Only the low 12 bits are used. The block then walks those bits out most significant first on a serial data line, with one rising strobe per bit. After the twelfth bit it issues a single active-low load pulse, which copies the assembled word into the converter's output register, and it flags completion with a one-cycle done pulse.

Every analog-side interval has its own timing parameter in nanoseconds: data setup before a strobe, strobe high width, data hold after the strobe, load width and clear width. Each is rounded up to whole clock cycles of the given period.

A separate clear request makes the block emit an active-low clear pulse of the minimum width, which returns the converter output to code zero. If a clear request arrives while a word is in flight, it is remembered and issued after that word completes.

Handshake rules: a word is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the block is idle and no clear is requested or pending. A host that keeps `req_valid` high while `req_ready` is low simply waits; its word is taken once ready returns. A request that is withdrawn before ready returns leaves no trace.

Top module: `sdl_word_loader`

## Requirements
- R1: After reset `dac_strobe` is 0, `dac_load_n` and `dac_clr_n` are 1, `busy` and `done` are 0 and `req_ready` is 1.
- R2: A word is accepted only on a clock edge with `req_valid` and `req_ready` both high. `req_ready` is high only when the block is idle with no clear requested or pending. `busy` is high from the cycle after acceptance through the done cycle.
- R3: The 12 bits `req_word[11:0]` go out on `dac_sdata` most significant bit (bit 11) first, with exactly 12 strobe pulses per word. `req_word[15:12]` has no effect.
- R4: `dac_sdata` holds each bit for at least SETUP cycles before the strobe rises.
- R5: The strobe stays high for at least STROBE cycles, and `dac_sdata` does not change while it is high.
- R6: `dac_sdata` stays unchanged for at least HOLD cycles after the strobe falls.
- R7: After the twelfth bit's hold, `dac_load_n` goes low once for LOAD cycles. It is never low while the strobe is high.
- R8: `done` is high for exactly one cycle, immediately after the load pulse, and `busy` is low in the next cycle.
- R9: A request raised while busy and withdrawn before `req_ready` returns causes no transfer.
- R10: A clear request drives `dac_clr_n` low for CLEAR cycles, with no strobe or load during that time.
- R11: When a clear request and a pending word meet in the same idle cycle, the clear pulse is issued first and the word is taken afterwards.
- R12: A clear request made during a transfer does not disturb the word. It is issued after that word's load pulse.
- R13: Each interval lasts ceil(time_ns / CLK_PERIOD_NS) cycles. With the defaults (10 ns clock; 50, 80, 30, 150, 200 ns) that is 5, 8, 3, 15 and 20 cycles. One word therefore keeps `busy` high for 12*16+15+1 = 208 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers a word |
| req_ready | output | 1 | Block can take a word this cycle |
| req_word | input | 16 | Right-justified word; low 12 bits are sent |
| clr_req | input | 1 | Request a converter clear pulse |
| busy | output | 1 | A word or clear is in progress |
| done | output | 1 | One-cycle pulse at the end of a word |
| dac_sdata | output | 1 | Serial data to the converter |
| dac_strobe | output | 1 | Bit strobe, data taken on its rising edge |
| dac_load_n | output | 1 | Active-low load of the assembled word |
| dac_clr_n | output | 1 | Active-low converter clear |

## Verification
A clear request and a word request can both reach the idle controller in the same cycle. The bench provokes this by raising `clr_req` and `req_valid` on the same clock. It judges the outcome by seeing `req_ready` held low, a complete clear pulse that precedes the first strobe, and the word then arriving intact. The second collision is a clear requested in the middle of a shift sequence. Here the bench checks that the twelve bits and the load pulse are unchanged and that the clear pulse only begins after the load pulse has ended.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_LOAD,
    ST_DONE,
    ST_CLEAR
  } sdl_state_e;

  // Whole cycles covering a duration, never less than one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdl_timer.sv
module sdl_timer #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdl_shifter.sv
module sdl_shifter #(
  parameter int NBITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [NBITS-1:0] word,
  output logic             msb
);

  logic [NBITS-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (load)  sh_q <= word;
    else if (shift) sh_q <= {sh_q[NBITS-2:0], 1'b0};
  end

  assign msb = sh_q[NBITS-1];

endmodule

// File: rtl/sdl_fsm.sv
module sdl_fsm
  import sdl_pkg::*;
#(
  parameter int NBITS     = 12,
  parameter int TW        = 5,
  parameter int SETUP_CYC = 5,
  parameter int STB_CYC   = 8,
  parameter int HOLD_CYC  = 3,
  parameter int LOAD_CYC  = 15,
  parameter int CLR_CYC   = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          clr_req,
  input  logic          tmr_exp,
  output sdl_state_e    state,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          sh_load,
  output logic          sh_shift,
  output logic          req_ready
);

  localparam int BW = $clog2(NBITS);

  sdl_state_e    state_q, state_d;
  logic [BW-1:0] bit_q;
  logic          clr_pend_q;
  logic          go_clear;
  logic          last_bit;

  assign go_clear  = (state_q == ST_IDLE) && (clr_req || clr_pend_q);
  assign req_ready = (state_q == ST_IDLE) && !clr_req && !clr_pend_q;
  assign last_bit  = (bit_q == BW'(NBITS - 1));

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go_clear) begin
          state_d  = ST_CLEAR;
          tmr_load = 1'b1;
          tmr_val  = TW'(CLR_CYC - 1);
        end else if (req_valid) begin
          state_d  = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = TW'(SETUP_CYC - 1);
          sh_load  = 1'b1;
        end
      end
      ST_SETUP: if (tmr_exp) begin
        state_d  = ST_STROBE;
        tmr_load = 1'b1;
        tmr_val  = TW'(STB_CYC - 1);
      end
      ST_STROBE: if (tmr_exp) begin
        state_d  = ST_HOLD;
        tmr_load = 1'b1;
        tmr_val  = TW'(HOLD_CYC - 1);
      end
      ST_HOLD: if (tmr_exp) begin
        tmr_load = 1'b1;
        if (last_bit) begin
          state_d = ST_LOAD;
          tmr_val = TW'(LOAD_CYC - 1);
        end else begin
          state_d  = ST_SETUP;
          tmr_val  = TW'(SETUP_CYC - 1);
          sh_shift = 1'b1;
        end
      end
      ST_LOAD:  if (tmr_exp) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      ST_CLEAR: if (tmr_exp) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bit_q      <= '0;
      clr_pend_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (sh_load)       bit_q <= '0;
      else if (sh_shift) bit_q <= bit_q + 1'b1;
      if (go_clear)      clr_pend_q <= 1'b0;
      else if (clr_req)  clr_pend_q <= 1'b1;
    end
  end

  assign state = state_q;

  // R12: a remembered clear never vanishes before its pulse starts
  a_r12_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pend_q && state_q != ST_IDLE) |=> clr_pend_q);

  // R3: the bit index never runs past the last bit
  a_r3_bit_range: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= BW'(NBITS - 1));

endmodule

// File: rtl/sdl_word_loader.sv
module sdl_word_loader
  import sdl_pkg::*;
#(
  parameter int HOST_W        = 16,
  parameter int NBITS         = 12,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_SETUP_NS    = 50,
  parameter int T_STB_NS      = 80,
  parameter int T_HOLD_NS     = 30,
  parameter int T_LOAD_NS     = 150,
  parameter int T_CLR_NS      = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [HOST_W-1:0] req_word,
  input  logic              clr_req,
  output logic              busy,
  output logic              done,
  output logic              dac_sdata,
  output logic              dac_strobe,
  output logic              dac_load_n,
  output logic              dac_clr_n
);

  localparam int SETUP_CYC = int'(ns_to_cyc(T_SETUP_NS, CLK_PERIOD_NS));
  localparam int STB_CYC   = int'(ns_to_cyc(T_STB_NS,   CLK_PERIOD_NS));
  localparam int HOLD_CYC  = int'(ns_to_cyc(T_HOLD_NS,  CLK_PERIOD_NS));
  localparam int LOAD_CYC  = int'(ns_to_cyc(T_LOAD_NS,  CLK_PERIOD_NS));
  localparam int CLR_CYC   = int'(ns_to_cyc(T_CLR_NS,   CLK_PERIOD_NS));
  localparam int MAX_CYC   = int'(max2(max2(max2(SETUP_CYC, STB_CYC), max2(HOLD_CYC, LOAD_CYC)), CLR_CYC));
  localparam int TW        = $clog2(MAX_CYC + 1);

  sdl_state_e    state;
  logic          tmr_load, tmr_exp, sh_load, sh_shift;
  logic [TW-1:0] tmr_val;

  sdl_fsm #(
    .NBITS(NBITS), .TW(TW), .SETUP_CYC(SETUP_CYC), .STB_CYC(STB_CYC),
    .HOLD_CYC(HOLD_CYC), .LOAD_CYC(LOAD_CYC), .CLR_CYC(CLR_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .clr_req(clr_req),
    .tmr_exp(tmr_exp), .state(state), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .sh_load(sh_load), .sh_shift(sh_shift), .req_ready(req_ready)
  );

  sdl_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  sdl_shifter #(.NBITS(NBITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .shift(sh_shift),
    .word(req_word[NBITS-1:0]), .msb(dac_sdata)
  );

  assign dac_strobe = (state == ST_STROBE);
  assign dac_load_n = (state != ST_LOAD);
  assign dac_clr_n  = (state != ST_CLEAR);
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_DONE);

  // Width trackers for the pulse-width checks
  logic [TW:0] stb_run_q, ld_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_run_q <= '0;
      ld_run_q  <= '0;
    end else begin
      stb_run_q <= dac_strobe  ? stb_run_q + 1'b1 : '0;
      ld_run_q  <= !dac_load_n ? ld_run_q + 1'b1  : '0;
    end
  end

  a_r5_sdata_steady: assert property (@(posedge clk) disable iff (!rst_n)
    dac_strobe |-> $stable(dac_sdata));

  a_r5_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_strobe) |-> (stb_run_q >= (TW+1)'(STB_CYC)));

  a_r7_load_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_load_n) |-> (ld_run_q >= (TW+1)'(LOAD_CYC)));

  a_r7_no_load_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(dac_strobe && !dac_load_n));

  a_r8_done_once: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);

  a_r10_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_clr_n |-> (dac_load_n && !dac_strobe));

endmodule

// File: tb/sdl_word_loader_tb.sv
module sdl_word_loader_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SETUP_E = (50  + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int STB_E   = (80  + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int HOLD_E  = (30  + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int LOAD_E  = (150 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int CLR_E   = (200 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int WORD_BUSY_E = 12 * (SETUP_E + STB_E + HOLD_E) + LOAD_E + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, clr_req = 1'b0;
  logic [15:0] req_word = '0;
  logic req_ready, busy, done, dac_sdata, dac_strobe, dac_load_n, dac_clr_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdl_word_loader #(.CLK_PERIOD_NS(CLK_PERIOD)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_word(req_word), .clr_req(clr_req), .busy(busy), .done(done),
    .dac_sdata(dac_sdata), .dac_strobe(dac_strobe), .dac_load_n(dac_load_n),
    .dac_clr_n(dac_clr_n)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Output monitor, sampled on the falling edge
  logic [11:0] cap;
  int nstb, nload, nclr, ndone, done_long, busy_after, overlap, stb_unstable;
  int data_run, since_fall, hi_run, lo_run, cl_run, busy_cnt;
  int min_setup, min_hi, min_hold, lo_width, cl_width, stb_at_load, stb_at_clr, load_at_clr;
  bit hold_open, p_ser, p_stb, p_load, p_clr, p_done;

  task automatic mon_clear();
    cap = '0; nstb = 0; nload = 0; nclr = 0; ndone = 0; done_long = 0; busy_after = 0;
    overlap = 0; stb_unstable = 0; hi_run = 0; lo_run = 0; cl_run = 0; busy_cnt = 0;
    min_setup = 9999; min_hi = 9999; min_hold = 9999; lo_width = -1; cl_width = -1;
    stb_at_load = -1; stb_at_clr = -1; load_at_clr = -1; hold_open = 0;
  endtask

  initial begin
    mon_clear();
    data_run = 0; since_fall = 0;
    p_ser = 0; p_stb = 0; p_load = 1; p_clr = 1; p_done = 0;
  end

  always @(negedge clk) if (rst_n) begin
    if (dac_sdata != p_ser) data_run = 1; else data_run++;
    since_fall++;
    if (busy) busy_cnt++;
    if (dac_strobe && !p_stb) begin
      cap = {cap[10:0], dac_sdata};
      nstb++;
      if (data_run - 1 < min_setup) min_setup = data_run - 1;
    end
    if (dac_strobe) hi_run++;
    if (dac_strobe && p_stb && dac_sdata != p_ser) stb_unstable++;
    if (!dac_strobe && p_stb) begin
      if (hi_run < min_hi) min_hi = hi_run;
      hi_run = 0; since_fall = 1; hold_open = 1;
    end
    if (hold_open && (dac_sdata != p_ser || !dac_load_n)) begin
      if (since_fall - 1 < min_hold) min_hold = since_fall - 1;
      hold_open = 0;
    end
    if (!dac_load_n) lo_run++;
    if (!dac_load_n && p_load) begin nload++; stb_at_load = nstb; end
    if (dac_load_n && !p_load) begin lo_width = lo_run; lo_run = 0; end
    if (!dac_clr_n) cl_run++;
    if (!dac_clr_n && p_clr) begin nclr++; stb_at_clr = nstb; load_at_clr = nload; end
    if (dac_clr_n && !p_clr) begin cl_width = cl_run; cl_run = 0; end
    if (!dac_load_n && dac_strobe) overlap++;
    if (!dac_clr_n && (dac_strobe || !dac_load_n)) overlap++;
    if (done) ndone++;
    if (done && p_done) done_long++;
    if (p_done && busy) busy_after++;
    p_ser = dac_sdata; p_stb = dac_strobe; p_load = dac_load_n; p_clr = dac_clr_n; p_done = done;
  end

  task automatic send_word(input logic [15:0] w);
    @(negedge clk);
    req_word = w; req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 4) begin
      @(negedge clk);
      if (busy) quiet = 0; else quiet++;
    end
  endtask

  task automatic t_reset();
    chk(dac_strobe == 0, "R1 strobe", dac_strobe, 0);
    chk(dac_load_n == 1, "R1 load_n", dac_load_n, 1);
    chk(dac_clr_n == 1,  "R1 clr_n", dac_clr_n, 1);
    chk(busy == 0,       "R1 busy", busy, 0);
    chk(done == 0,       "R1 done", done, 0);
    chk(req_ready == 1,  "R1 ready", req_ready, 1);
  endtask

  task automatic t_word(input logic [15:0] w);
    mon_clear();
    send_word(w);
    chk(busy == 1,      "R2 busy after accept", busy, 1);
    chk(req_ready == 0, "R2 ready while busy", req_ready, 0);
    wait_idle();
    chk(cap == w[11:0], "R3 word bits", cap, w[11:0]);
    chk(nstb == 12,     "R3 strobe count", nstb, 12);
    chk(min_setup >= SETUP_E, "R4 setup", min_setup, SETUP_E);
    chk(min_hi >= STB_E,      "R5 strobe width", min_hi, STB_E);
    chk(stb_unstable == 0,    "R5 data in strobe", stb_unstable, 0);
    chk(min_hold >= HOLD_E,   "R6 hold", min_hold, HOLD_E);
    chk(nload == 1,           "R7 load count", nload, 1);
    chk(stb_at_load == 12,    "R7 load after bits", stb_at_load, 12);
    chk(lo_width == LOAD_E,   "R7 load width", lo_width, LOAD_E);
    chk(overlap == 0,         "R7 overlap", overlap, 0);
    chk(ndone == 1 && done_long == 0, "R8 done pulse", ndone, 1);
    chk(busy_after == 0,      "R8 busy after done", busy_after, 0);
    chk(busy_cnt == WORD_BUSY_E, "R13 busy cycles", busy_cnt, WORD_BUSY_E);
  endtask

  task automatic t_ignore_busy();
    mon_clear();
    send_word(16'h03C3);
    repeat (40) @(negedge clk);
    req_word = 16'h00F0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    repeat (20) @(negedge clk);
    chk(cap == 12'h3C3, "R9 word kept", cap, 12'h3C3);
    chk(nstb == 12,     "R9 no second transfer", nstb, 12);
    chk(ndone == 1,     "R9 single done", ndone, 1);
  endtask

  task automatic t_clear();
    mon_clear();
    @(negedge clk); clr_req = 1'b1;
    @(negedge clk); clr_req = 1'b0;
    wait_idle();
    chk(nclr == 1,         "R10 clear count", nclr, 1);
    chk(cl_width == CLR_E, "R10 clear width", cl_width, CLR_E);
    chk(overlap == 0 && nstb == 0 && nload == 0, "R10 quiet during clear", overlap, 0);
  endtask

  task automatic t_clr_and_start();
    mon_clear();
    @(negedge clk);
    clr_req = 1'b1; req_valid = 1'b1; req_word = 16'h0A5F;
    #1;
    chk(req_ready == 0, "R11 ready low on clear", req_ready, 0);
    @(negedge clk); clr_req = 1'b0;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk); req_valid = 1'b0;
    wait_idle();
    chk(nclr == 1,       "R11 clear issued", nclr, 1);
    chk(stb_at_clr == 0, "R11 clear before word", stb_at_clr, 0);
    chk(cap == 12'hA5F && nstb == 12, "R11 word after clear", cap, 12'hA5F);
  endtask

  task automatic t_clr_busy();
    mon_clear();
    send_word(16'h0C35);
    repeat (60) @(negedge clk);
    clr_req = 1'b1;
    @(negedge clk); clr_req = 1'b0;
    wait_idle();
    chk(cap == 12'hC35 && nstb == 12, "R12 word intact", cap, 12'hC35);
    chk(nclr == 1,        "R12 clear issued", nclr, 1);
    chk(load_at_clr == 1, "R12 clear after load", load_at_clr, 1);
    chk(overlap == 0,     "R12 no overlap", overlap, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word(16'h0A5C);
    t_word(16'h0FFF);
    t_word(16'h0000);
    t_word(16'hF5A3);   // R3: upper nibble ignored
    t_word(16'h0801);
    t_ignore_busy();
    t_clear();
    t_clr_and_start();
    t_clr_busy();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

endmodule